// File: doc/BRIEF.md
# Asynchronous Bus Read Handshake

This block joins an I/O-side requester and a memory-side responder across a shared bus that carries no clock. Each side runs on its own clock. The read is fully interlocked. The requester puts an address on the bus and raises a request line. The responder takes the address and acknowledges it. The requester then lets go of the bus. Later the responder puts the read word on the same bus and raises a data-ready line. The requester captures the word and acknowledges it, and both sides return their lines low. Every control line that one side reads from the other passes through a two-flop synchronizer before a state machine acts on it.

Reads enter through a valid/ready address stream on the requester clock. A request is taken on a cycle where `in_valid` and `in_ready` are both high. The requester keeps at most one read and at most one returned word. `in_ready` stays low while a word waits on the output or while any bus control line is still high. The returned word leaves through a valid/ready stream. `out_valid` stays high and `out_data` holds its value until the cycle `out_ready` is high. The responder's storage is a small table of constant words. A programmable wait, counted in responder clock cycles, models the access time.

Top module: `hs_read_link`

## Requirements
- R1: While either reset is active, and just after both are released, `line_req`, `line_ack`, `line_rdy`, `req_oe`, `rsp_oe` and `out_valid` are low and `in_ready` is high.
- R2: In the requester cycle after a request is accepted, `line_req` and `req_oe` are high and `bus_val[AW-1:0]` holds the accepted address.
- R3: The requester drops `line_req` and `req_oe`, both in the same cycle, only while `line_ack` is high.
- R4: The responder drops its acknowledge only after `line_req` is low. It raises `line_rdy` only while `line_req` and `line_ack` are both low.
- R5: `line_rdy` rises together with `rsp_oe` exactly `rsp_latency + 4` responder clock cycles after `line_ack` falls. At that moment `bus_val[DW-1:0]` carries the read word.
- R6: `req_oe` and `rsp_oe` are never high at the same time.
- R7: After `line_rdy` rises, the requester raises `line_ack`. The responder drops `line_rdy` and `rsp_oe` only while `line_ack` is high. The requester then drops `line_ack`, so all three lines return low.
- R8: The word returned for address a is (a*37 + 11) mod 2^DW. With the default DW = 8 this is (a*37 + 11) & 0xFF.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays stable and no new request starts. The word leaves on the first cycle where `out_ready` is high.
- R10: A new request is accepted only once `line_req`, `line_ack` and `line_rdy` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_clk | input | 1 | Requester clock |
| req_rst_n | input | 1 | Requester asynchronous reset, active low |
| rsp_clk | input | 1 | Responder clock |
| rsp_rst_n | input | 1 | Responder asynchronous reset, active low |
| rsp_latency | input | LW (4) | Access wait in responder cycles; hold it stable while a read is in flight |
| in_valid | input | 1 | Address stream valid |
| in_ready | output | 1 | Address stream ready |
| in_addr | input | AW (4) | Read address |
| out_valid | output | 1 | Returned word valid |
| out_ready | input | 1 | Returned word ready |
| out_data | output | DW (8) | Returned word |
| line_req | output | 1 | Read request line (requester drives it) |
| line_ack | output | 1 | Acknowledge line, OR of both sides' acknowledges |
| line_rdy | output | 1 | Data-ready line (responder drives it) |
| req_oe | output | 1 | Requester bus drive enable |
| rsp_oe | output | 1 | Responder bus drive enable |
| bus_val | output | max(AW,DW) (8) | Value on the shared address/data bus |

## Verification
Two things can coincide. The returned word can sit held on the output stream while a new address is already offered on the input. The responder can also be told to drive read data at the moment the requester has just let go of the bus. The bench covers the first by holding `out_ready` low for random spans with `in_valid` high. During those spans it expects `line_req` to stay low and `out_data` to stay frozen. It covers the second with random access waits that include zero. It watches both drive enables on every edge of either clock, and it checks that `line_rdy` rises only after `line_req` and `line_ack` have both fallen.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int MEM_MUL = 37;
  localparam int MEM_ADD = 11;

  typedef enum logic [1:0] {
    RQ_IDLE,
    RQ_ADDR,
    RQ_WAIT,
    RQ_ACK
  } rq_state_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ACKED,
    RS_SETTLE,
    RS_WAIT,
    RS_DRIVE,
    RS_END
  } rs_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import hs_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int BW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          ack_line,
  input  logic          rdy_line,
  input  logic [DW-1:0] bus_in,
  output logic          req_line,
  output logic          dev_ack,
  output logic          oe,
  output logic [BW-1:0] bus_out
);
  logic [1:0]    sync_q;
  logic          ack_s, rdy_s;
  rq_state_t     st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          vld_q, req_q, ack_q;

  hs_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ack_line, rdy_line}),
    .q    (sync_q)
  );
  assign ack_s = sync_q[1];
  assign rdy_s = sync_q[0];

  // one read in flight, one word held, all lines seen low
  assign in_ready = (st == RQ_IDLE) && !ack_s && !rdy_s && !vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RQ_IDLE;
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (vld_q && out_ready) vld_q <= 1'b0;
      unique case (st)
        RQ_IDLE: if (in_valid && in_ready) begin
          addr_q <= in_addr;
          req_q  <= 1'b1;
          st     <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          req_q <= 1'b0;
          st    <= RQ_WAIT;
        end
        RQ_WAIT: if (rdy_s) begin
          data_q <= bus_in;
          vld_q  <= 1'b1;
          ack_q  <= 1'b1;
          st     <= RQ_ACK;
        end
        RQ_ACK: if (!rdy_s) begin
          ack_q <= 1'b0;
          st    <= RQ_IDLE;
        end
        default: st <= RQ_IDLE;
      endcase
    end
  end

  assign req_line  = req_q;
  assign oe        = req_q;
  assign dev_ack   = ack_q;
  assign bus_out   = BW'(addr_q);
  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int BW     = 8,
  parameter int LW     = 4,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] latency,
  input  logic          req_line,
  input  logic          ack_line,
  input  logic [AW-1:0] bus_in,
  output logic          mem_ack,
  output logic          rdy,
  output logic          oe,
  output logic [BW-1:0] bus_out
);
  localparam int DEPTH = 1 << AW;

  logic [1:0]    sync_q;
  logic          req_s, ack_s;
  rs_state_t     st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dat_q;
  logic [LW-1:0] cnt;
  logic          ack_q, rdy_q;
  logic [DW-1:0] word_tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign word_tbl[i] = DW'(i * MEM_MUL + MEM_ADD);
  end

  hs_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({req_line, ack_line}),
    .q    (sync_q)
  );
  assign req_s = sync_q[1];
  assign ack_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RS_IDLE;
      addr_q <= '0;
      dat_q  <= '0;
      cnt    <= '0;
      ack_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      unique case (st)
        RS_IDLE: if (req_s && !ack_s) begin
          addr_q <= bus_in;
          ack_q  <= 1'b1;
          st     <= RS_ACKED;
        end
        RS_ACKED: if (!req_s) begin
          ack_q <= 1'b0;
          st    <= RS_SETTLE;
        end
        // wait until the dropped acknowledge has cleared the synchronizer
        RS_SETTLE: if (!ack_s) begin
          cnt <= latency;
          st  <= RS_WAIT;
        end
        RS_WAIT: begin
          if (cnt == '0) begin
            dat_q <= word_tbl[addr_q];
            rdy_q <= 1'b1;
            st    <= RS_DRIVE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RS_DRIVE: if (ack_s) begin
          rdy_q <= 1'b0;
          st    <= RS_END;
        end
        RS_END: if (!ack_s) st <= RS_IDLE;
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign mem_ack = ack_q;
  assign rdy     = rdy_q;
  assign oe      = rdy_q;
  assign bus_out = BW'(dat_q);
endmodule

// File: rtl/hs_read_link.sv
module hs_read_link
  import hs_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int LW     = 4,
  parameter int STAGES = 2
) (
  input  logic                         req_clk,
  input  logic                         req_rst_n,
  input  logic                         rsp_clk,
  input  logic                         rsp_rst_n,
  input  logic [LW-1:0]                rsp_latency,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [AW-1:0]                in_addr,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DW-1:0]                out_data,
  output logic                         line_req,
  output logic                         line_ack,
  output logic                         line_rdy,
  output logic                         req_oe,
  output logic                         rsp_oe,
  output logic [((AW > DW) ? AW : DW)-1:0] bus_val
);
  localparam int BW = (AW > DW) ? AW : DW;

  logic          dev_ack, mem_ack;
  logic [BW-1:0] req_bus, rsp_bus;

  hs_requester #(.AW(AW), .DW(DW), .BW(BW), .STAGES(STAGES)) u_req (
    .clk      (req_clk),
    .rst_n    (req_rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_addr  (in_addr),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .ack_line (line_ack),
    .rdy_line (line_rdy),
    .bus_in   (bus_val[DW-1:0]),
    .req_line (line_req),
    .dev_ack  (dev_ack),
    .oe       (req_oe),
    .bus_out  (req_bus)
  );

  hs_responder #(.AW(AW), .DW(DW), .BW(BW), .LW(LW), .STAGES(STAGES)) u_rsp (
    .clk     (rsp_clk),
    .rst_n   (rsp_rst_n),
    .latency (rsp_latency),
    .req_line(line_req),
    .ack_line(line_ack),
    .bus_in  (bus_val[AW-1:0]),
    .mem_ack (mem_ack),
    .rdy     (line_rdy),
    .oe      (rsp_oe),
    .bus_out (rsp_bus)
  );

  // the acknowledge line is shared: either side may pull it high
  assign line_ack = dev_ack | mem_ack;
  // the bus carries whatever the enabled side drives
  assign bus_val  = ({BW{req_oe}} & req_bus) | ({BW{rsp_oe}} & rsp_bus);
endmodule

// File: rtl/hs_read_link_chk.sv
module hs_read_link_chk #(
  parameter int DW = 8
) (
  input logic          req_clk,
  input logic          req_rst_n,
  input logic          rsp_clk,
  input logic          rsp_rst_n,
  input logic          line_req,
  input logic          line_ack,
  input logic          line_rdy,
  input logic          req_oe,
  input logic          rsp_oe,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  p_drive_excl_r6: assert property (@(posedge req_clk) disable iff (!req_rst_n || !rsp_rst_n)
    !(req_oe && rsp_oe));

  p_req_release_r3: assert property (@(posedge req_clk) disable iff (!req_rst_n || !rsp_rst_n)
    $fell(line_req) |-> line_ack);

  p_new_req_r10: assert property (@(posedge req_clk) disable iff (!req_rst_n || !rsp_rst_n)
    $rose(line_req) |-> (!$past(line_ack) && !$past(line_rdy)));

  p_out_hold_r9: assert property (@(posedge req_clk) disable iff (!req_rst_n || !rsp_rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_ack_drop_r4: assert property (@(posedge rsp_clk) disable iff (!req_rst_n || !rsp_rst_n)
    $fell(mem_ack) |-> !line_req);

  p_rdy_order_r4: assert property (@(posedge rsp_clk) disable iff (!req_rst_n || !rsp_rst_n)
    $rose(line_rdy) |-> (!line_req && !line_ack));

  p_rdy_release_r7: assert property (@(posedge rsp_clk) disable iff (!req_rst_n || !rsp_rst_n)
    $fell(line_rdy) |-> line_ack);
endmodule

bind hs_read_link hs_read_link_chk #(.DW(DW)) u_chk (
  .req_clk  (req_clk),
  .req_rst_n(req_rst_n),
  .rsp_clk  (rsp_clk),
  .rsp_rst_n(rsp_rst_n),
  .line_req (line_req),
  .line_ack (line_ack),
  .line_rdy (line_rdy),
  .req_oe   (req_oe),
  .rsp_oe   (rsp_oe),
  .mem_ack  (mem_ack),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/tb_hs_read_link.sv
`timescale 1ns/1ps
module tb_hs_read_link;
  localparam int CLK_PERIOD = 10;
  localparam int RSP_PERIOD = 14;

  logic       req_clk = 1'b0, rsp_clk = 1'b0;
  logic       req_rst_n = 1'b0, rsp_rst_n = 1'b0;
  logic [3:0] rsp_latency = '0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [3:0] in_addr = '0;
  logic       in_ready, out_valid, line_req, line_ack, line_rdy, req_oe, rsp_oe;
  logic [7:0] out_data, bus_val;

  int n_tests = 0, n_fail = 0;
  bit r3_bad = 0, r4_bad = 0, r6_bad = 0, r7_bad = 0, r10_bad = 0;
  int gap = 0, gap_at_rdy = 0;
  logic [7:0] bus_at_rdy = '0;
  logic oe_at_rdy = 1'b0;

  always #(CLK_PERIOD/2) req_clk = ~req_clk;
  always #(RSP_PERIOD/2) rsp_clk = ~rsp_clk;

  hs_read_link dut (
    .req_clk(req_clk), .req_rst_n(req_rst_n), .rsp_clk(rsp_clk), .rsp_rst_n(rsp_rst_n),
    .rsp_latency(rsp_latency), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .line_req(line_req), .line_ack(line_ack), .line_rdy(line_rdy),
    .req_oe(req_oe), .rsp_oe(rsp_oe), .bus_val(bus_val)
  );

  function automatic logic [7:0] mem_word(input logic [3:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // protocol order monitors
  always @(negedge line_req) if (req_rst_n && !line_ack) r3_bad = 1;
  always @(posedge line_rdy) if (line_req || line_ack) r4_bad = 1;
  always @(negedge line_rdy) if (rsp_rst_n && !line_ack) r7_bad = 1;
  always @(negedge line_ack) if (line_req) r4_bad = 1;
  always @(negedge req_clk or negedge rsp_clk) if (req_oe && rsp_oe) r6_bad = 1;
  always @(negedge req_clk) if (in_ready && (line_req || line_ack || line_rdy)) r10_bad = 1;

  // responder cycles since the acknowledge line fell
  always @(negedge rsp_clk) gap = line_ack ? 0 : gap + 1;
  always @(posedge line_rdy) begin
    #1;
    gap_at_rdy = gap;
    bus_at_rdy = bus_val;
    oe_at_rdy  = rsp_oe;
  end

  task automatic run_txn(input logic [3:0] a, input logic [3:0] lat, input int hold);
    logic [7:0] exp;
    bit held_ok;
    int quiet;
    exp = mem_word(a);
    held_ok = 1;
    while (line_req || line_ack || line_rdy) @(negedge req_clk);
    rsp_latency = lat;
    in_addr  = a;
    in_valid = 1'b1;
    while (!in_ready) @(negedge req_clk);
    @(negedge req_clk);
    in_valid = 1'b0;
    chk(line_req && req_oe && bus_val[3:0] == a, "R2 address on bus", int'(bus_val[3:0]), int'(a));
    while (!out_valid) @(negedge req_clk);
    chk(gap_at_rdy == int'(lat) + 4, "R5 data-ready delay", gap_at_rdy, int'(lat) + 4);
    chk(oe_at_rdy && bus_at_rdy == exp, "R5 bus word at data-ready", int'(bus_at_rdy), int'(exp));
    chk(out_data == exp, "R8 returned word", int'(out_data), int'(exp));
    if (hold > 0) begin
      in_addr  = ~a;
      in_valid = 1'b1;
      for (int i = 0; i < hold; i++) begin
        @(negedge req_clk);
        if (!out_valid || out_data != exp || line_req || req_oe) held_ok = 0;
      end
      chk(held_ok, "R9 held word and no new request", int'(out_data), int'(exp));
      in_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(negedge req_clk);
    out_ready = 1'b0;
    chk(!out_valid, "R9 word leaves on ready", int'(out_valid), 0);
    quiet = 0;
    while ((line_req || line_ack || line_rdy) && quiet < 40) begin
      @(negedge req_clk);
      quiet++;
    end
    chk(!line_req && !line_ack && !line_rdy, "R7 lines return low", quiet, 40);
  endtask

  initial begin
    repeat (100000) @(posedge req_clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5A17);
    repeat (3) @(negedge req_clk);
    chk(!line_req && !line_ack && !line_rdy && !req_oe && !rsp_oe && !out_valid,
        "R1 reset quiet", int'({line_req, line_ack, line_rdy, req_oe, rsp_oe, out_valid}), 0);
    req_rst_n = 1'b1;
    rsp_rst_n = 1'b1;
    @(negedge req_clk);
    @(negedge req_clk);
    chk(in_ready && !out_valid && !line_req, "R1 ready after reset", int'(in_ready), 1);

    // directed corners
    run_txn(4'd0,  4'd0,  0);
    run_txn(4'd15, 4'd15, 3);
    run_txn(4'd7,  4'd0,  0);
    run_txn(4'd7,  4'd1,  1);

    // random mix
    for (int t = 0; t < 40; t++) begin
      run_txn(4'($urandom_range(15)), 4'($urandom_range(15)), int'($urandom_range(3)));
    end

    chk(!r3_bad,  "R3 request dropped only under acknowledge", int'(r3_bad), 0);
    chk(!r4_bad,  "R4 acknowledge and data-ready ordering", int'(r4_bad), 0);
    chk(!r6_bad,  "R6 drive enables exclusive", int'(r6_bad), 0);
    chk(!r7_bad,  "R7 data-ready dropped only under acknowledge", int'(r7_bad), 0);
    chk(!r10_bad, "R10 ready only with all lines low", int'(r10_bad), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule